// File: doc/BRIEF.md
# Fractional SPI Serial Clock Generator

This block derives a serial clock for an SPI shift engine from a fast reference clock. It does not divide by an integer. A phase accumulator adds a frequency word to itself on every reference cycle, and the serial clock changes level each time the phase crosses a half-period boundary. One full serial period is 2048 phase units, so the serial rate is the reference rate times the word divided by 2048. Software picks the word as the ceiling of 2048 over the integer divide ratio it wants.

Around the accumulator, the block produces two single-cycle strobes for the shift engine. The capture strobe marks the cycle in which the serial clock has just made the edge chosen for sampling. The drive strobe comes one reference cycle ahead of the edge chosen for changing output data. Each strobe has its own rising/falling selection, and a polarity input sets the idle level. A transfer-start pulse can optionally clear the phase, so every transfer begins with the same timing. A flag chosen for fast rates, which asks for asynchronous input sampling, is captured at each start and held for the whole transfer. While the engine is idle the serial clock stays at its idle level. A gate control decides whether the phase freezes or keeps running during that time.

Top module: `sck_frac_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `sck`, `latch_stb`, `launch_stb` and `async_in` are all 0.
- R2: On each cycle with `busy`=1 and `start`=0, the phase (modulo 2048) advances by step = min(`freq_word`, 1024). The level of `sck` toggles, one cycle later, each time the phase crosses a multiple of 1024. A word of 1024 toggles every cycle, and a word of 0 never toggles.
- R3: Any `freq_word` above 1024 behaves exactly as 1024 (half the reference rate).
- R4: A cycle with `busy`=0 drives `sck` to `cpol` at the next clock edge, and no strobe is raised for that cycle.
- R5: A `start` pulse with `loop_restart`=1 clears the phase to 0 and does not advance it in that cycle.
- R6: A `start` pulse with `loop_restart`=0 keeps the phase as it was, without advancing it.
- R7: While `busy`=0, `gate_en`=1 freezes the phase, and `gate_en`=0 lets it keep advancing. In both cases `sck` stays at `cpol`.
- R8: `latch_stb` is 1 in exactly the cycles in which `sck` shows a new level produced by an advance while busy. It fires on rising edges when `latch_rise`=1 and on falling edges when `latch_rise`=0.
- R9: `launch_stb` is 1 in the cycle just before `sck` makes an edge, provided `busy` stays 1 with no `start`. It fires for rising edges when `launch_rise`=1 and for falling edges when `launch_rise`=0.
- R10: The active level of `sck` is taken relative to `cpol`. With `cpol`=1 the clock idles high and its first edge in a transfer is falling.
- R11: `async_in` takes the value of `async_sel` at each `start` pulse and holds it until the next `start`.
- R12: In the cycle after a `start` pulse, `sck` equals `cpol`, and the toggle state restarts from the idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word | input | 14 | Phase increment per reference cycle |
| loop_restart | input | 1 | Clear the phase on `start` |
| latch_rise | input | 1 | 1: capture on rising edge, 0: on falling |
| launch_rise | input | 1 | 1: drive data on rising edge, 0: on falling |
| async_sel | input | 1 | Asynchronous input sampling request, captured at `start` |
| cpol | input | 1 | Idle level of `sck` |
| gate_en | input | 1 | Freeze the phase while idle |
| busy | input | 1 | Shift engine is transferring |
| start | input | 1 | One-cycle transfer start pulse |
| sck | output | 1 | Serial clock |
| latch_stb | output | 1 | Capture strobe, coincident with the capture edge |
| launch_stb | output | 1 | Drive strobe, one cycle before the drive edge |
| async_in | output | 1 | Captured asynchronous sampling flag |

## Verification
The capture strobe for one edge and the drive strobe that looks ahead to the next edge can both be high in the same cycle. At a word of 1024 every cycle is an edge, and with capture on rising and drive on falling, each rising edge of `sck` carries both strobes together. The bench sets up that case right after a restart. A cycle-level model built from the requirements predicts each strobe on its own, so losing either one in the shared cycle is reported. A second overlap occurs when `start` falls on a cycle in which the phase would otherwise wrap. The bench checks that no capture strobe appears there and that the drive strobe reflects the cleared phase.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;

    // Default widths: 14-bit increment word, 2048-unit phase circle.
    localparam int DEF_WORD_W  = 14;
    localparam int DEF_PHASE_W = 11;

    // Strobe pair handed to the shift engine.
    typedef struct packed {
        logic latch;
        logic launch;
    } sck_strobe_t;

endpackage

// File: rtl/sck_step_clamp.sv
// Limits the per-cycle increment to half the phase circle, so at most
// one half-period boundary is crossed per reference cycle.
module sck_step_clamp #(
    parameter int WORD_W  = 14,
    parameter int PHASE_W = 11
) (
    input  logic [WORD_W-1:0]  word,
    output logic [PHASE_W-1:0] step
);
    localparam int HALF = 1 << (PHASE_W - 1);
    localparam logic [WORD_W-1:0] HALF_W = WORD_W'(HALF);

    always_comb begin
        if (word >= HALF_W) begin
            step = PHASE_W'(HALF);
        end else begin
            step = word[PHASE_W-1:0];
        end
    end
endmodule

// File: rtl/sck_wrap_detect.sv
// Flags whether adding step to phase crosses a half-period boundary.
module sck_wrap_detect #(
    parameter int PHASE_W = 11
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic [PHASE_W-1:0] step,
    output logic               wrap
);
    logic [PHASE_W-1:0] low_sum;

    always_comb begin
        low_sum = {1'b0, phase[PHASE_W-2:0]} + step;
        wrap    = low_sum[PHASE_W-1];
    end
endmodule

// File: rtl/sck_phase_adv.sv
// One accumulator step: next phase modulo the circle plus boundary flag.
module sck_phase_adv #(
    parameter int PHASE_W = 11
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase_nxt,
    output logic               wrap
);
    sck_wrap_detect #(.PHASE_W(PHASE_W)) u_wrap (
        .phase (phase),
        .step  (step),
        .wrap  (wrap)
    );

    assign phase_nxt = phase + step;
endmodule

// File: rtl/sck_edge_match.sv
// Qualifies an edge of the given new level against a rise/fall choice.
module sck_edge_match (
    input  logic valid,
    input  logic level,
    input  logic rise_sel,
    output logic hit
);
    assign hit = valid & (level == rise_sel);
endmodule

// File: rtl/sck_frac_gen.sv
module sck_frac_gen
    import sck_gen_pkg::*;
#(
    parameter int WORD_W  = DEF_WORD_W,
    parameter int PHASE_W = DEF_PHASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] freq_word,
    input  logic              loop_restart,
    input  logic              latch_rise,
    input  logic              launch_rise,
    input  logic              async_sel,
    input  logic              cpol,
    input  logic              gate_en,
    input  logic              busy,
    input  logic              start,
    output logic              sck,
    output logic              latch_stb,
    output logic              launch_stb,
    output logic              async_in
);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               lvl;
        logic               sck;
        sck_strobe_t        stb;
        logic               async_f;
    } gen_state_t;

    gen_state_t st_q, st_d;

    logic [PHASE_W-1:0] step;
    logic [PHASE_W-1:0] adv_phase;
    logic [PHASE_W-1:0] phase_nx;
    logic               adv_wrap;
    logic               ahead_wrap;
    logic               lvl_nx;
    logic               advance;
    logic               edge_now;
    logic               sck_nx;
    logic               ahead_level;
    logic               lat_hit;
    logic               lau_hit;

    sck_step_clamp #(.WORD_W(WORD_W), .PHASE_W(PHASE_W)) u_clamp (
        .word (freq_word),
        .step (step)
    );

    sck_phase_adv #(.PHASE_W(PHASE_W)) u_adv (
        .phase     (st_q.phase),
        .step      (step),
        .phase_nxt (adv_phase),
        .wrap      (adv_wrap)
    );

    // Phase and toggle state for the coming edge.
    always_comb begin : p_phase
        advance  = gate_en ? busy : 1'b1;
        phase_nx = st_q.phase;
        lvl_nx   = st_q.lvl;
        edge_now = 1'b0;
        if (start) begin
            phase_nx = loop_restart ? '0 : st_q.phase;
            lvl_nx   = 1'b0;
        end else if (advance) begin
            phase_nx = adv_phase;
            lvl_nx   = st_q.lvl ^ adv_wrap;
            edge_now = busy & adv_wrap;
        end
        sck_nx      = cpol ^ (busy & lvl_nx);
        ahead_level = cpol ^ ~lvl_nx;
    end

    // Look one cycle further to place the drive strobe ahead of its edge.
    sck_wrap_detect #(.PHASE_W(PHASE_W)) u_ahead (
        .phase (phase_nx),
        .step  (step),
        .wrap  (ahead_wrap)
    );

    sck_edge_match u_latch_sel (
        .valid    (edge_now),
        .level    (sck_nx),
        .rise_sel (latch_rise),
        .hit      (lat_hit)
    );

    sck_edge_match u_launch_sel (
        .valid    (busy & ahead_wrap),
        .level    (ahead_level),
        .rise_sel (launch_rise),
        .hit      (lau_hit)
    );

    always_comb begin : p_next
        st_d            = st_q;
        st_d.phase      = phase_nx;
        st_d.lvl        = lvl_nx;
        st_d.sck        = sck_nx;
        st_d.stb.latch  = lat_hit;
        st_d.stb.launch = lau_hit;
        st_d.async_f    = start ? async_sel : st_q.async_f;
    end

    always_ff @(posedge clk) begin : p_reg
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck        = st_q.sck;
    assign latch_stb  = st_q.stb.latch;
    assign launch_stb = st_q.stb.launch;
    assign async_in   = st_q.async_f;

endmodule

// File: rtl/sck_frac_gen_sva.sv
module sck_frac_gen_sva #(
    parameter int WORD_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] freq_word,
    input logic              cpol,
    input logic              busy,
    input logic              start,
    input logic              sck,
    input logic              latch_stb,
    input logic              launch_stb,
    input logic              async_in
);

    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (sck == $past(cpol)));

    a_r12_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sck == $past(cpol)));

    a_r8_latch_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_stb && $stable(cpol)) |-> (sck != $past(sck)));

    a_r8_latch_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |-> ($past(busy) && !$past(start)));

    a_r9_launch_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> $past(busy));

    a_r11_async_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (async_in == $past(async_in)));

    a_r2_zero_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && $past(busy, 2) && !$past(start) &&
         ($past(freq_word) == '0) && ($past(cpol) == $past(cpol, 2)))
        |-> (sck == $past(sck)));

endmodule

bind sck_frac_gen sck_frac_gen_sva #(.WORD_W(WORD_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq_word  (freq_word),
    .cpol       (cpol),
    .busy       (busy),
    .start      (start),
    .sck        (sck),
    .latch_stb  (latch_stb),
    .launch_stb (launch_stb),
    .async_in   (async_in)
);

// File: tb/sim_sck_frac_gen.sv
`timescale 1ns/1ps
module sim_sck_frac_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] freq_word = '0;
    logic        loop_restart = 1'b1;
    logic        latch_rise = 1'b1;
    logic        launch_rise = 1'b0;
    logic        async_sel = 1'b0;
    logic        cpol = 1'b0;
    logic        gate_en = 1'b1;
    logic        busy = 1'b0;
    logic        start = 1'b0;
    logic        sck, latch_stb, launch_stb, async_in;

    always #4 clk = ~clk;

    sck_frac_gen u0 (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word),
        .loop_restart(loop_restart), .latch_rise(latch_rise),
        .launch_rise(launch_rise), .async_sel(async_sel), .cpol(cpol),
        .gate_en(gate_en), .busy(busy), .start(start), .sck(sck),
        .latch_stb(latch_stb), .launch_stb(launch_stb), .async_in(async_in)
    );

    typedef struct packed {
        logic sck;
        logic lat;
        logic lau;
        logic asy;
    } exp_t;

    exp_t  exq[$];
    string tagq[$];
    int    checks = 0;
    int    fails = 0;
    int    rises = 0;
    logic  prev_sck = 1'b0;

    // Reference model state, from the requirements.
    int m_acc = 0;
    bit m_lvl = 0;
    bit m_async = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic cyc(input logic b, input logic s, input string tag);
        int   stp;
        int   old;
        bit   crossed;
        exp_t e;
        busy  = b;
        start = s;
        stp = (freq_word > 14'd1024) ? 1024 : int'(freq_word);
        crossed = 0;
        if (s) begin
            if (loop_restart) m_acc = 0;
            m_lvl   = 0;
            m_async = async_sel;
        end else if (!gate_en || b) begin
            old     = m_acc;
            crossed = ((old % 1024) + stp) >= 1024;
            m_acc   = (old + stp) % 2048;
            m_lvl   = m_lvl ^ crossed;
        end
        e.sck = cpol ^ (b & m_lvl);
        e.lat = b && crossed && (e.sck == latch_rise);
        e.lau = b && (((m_acc % 1024) + stp) >= 1024) && ((cpol ^ !m_lvl) == launch_rise);
        e.asy = m_async;
        exq.push_back(e);
        tagq.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compares the design against the queued expectations.
    always @(posedge clk) begin
        #2;
        if (rst_n && exq.size() > 0) begin
            exp_t  e;
            string t;
            e = exq.pop_front();
            t = tagq.pop_front();
            check(t, "sck", int'(sck), int'(e.sck));
            check(t, "latch_stb", int'(latch_stb), int'(e.lat));
            check(t, "launch_stb", int'(launch_stb), int'(e.lau));
            check(t, "async_in", int'(async_in), int'(e.asy));
        end
        if (rst_n && sck && !prev_sck) rises++;
        prev_sck = sck;
    end

    bit done = 0;
    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "sck", int'(sck), 0);
        check("R1", "latch_stb", int'(latch_stb), 0);
        check("R1", "launch_stb", int'(launch_stb), 0);
        check("R1", "async_in", int'(async_in), 0);
        rst_n = 1'b1;
        cyc(0, 0, "R1");
        cyc(0, 0, "R4");

        // R8/R9 coincide: word 1024, capture rising, drive falling
        freq_word = 14'd1024; latch_rise = 1; launch_rise = 0;
        cyc(1, 1, "R5");
        for (int i = 0; i < 12; i++) cyc(1, 0, "R8");
        cyc(0, 0, "R4");

        // R2: word 256, four rises over 32 advances
        freq_word = 14'd256;
        r0 = rises;
        cyc(1, 1, "R5");
        for (int i = 0; i < 32; i++) cyc(1, 0, "R2");
        cyc(0, 0, "R4");
        cyc(0, 0, "R4");
        check("R2", "rises", rises - r0, 4);

        // R3: word above 1024 clamps to half rate
        freq_word = 14'd5000;
        r0 = rises;
        cyc(1, 1, "R3");
        for (int i = 0; i < 8; i++) cyc(1, 0, "R3");
        cyc(0, 0, "R4");
        cyc(0, 0, "R4");
        check("R3", "rises", rises - r0, 4);

        // R2: word 0 never toggles
        freq_word = 14'd0;
        r0 = rises;
        cyc(1, 1, "R2");
        for (int i = 0; i < 6; i++) cyc(1, 0, "R2");
        cyc(0, 0, "R4");
        check("R2", "rises_zero", rises - r0, 0);

        // R6: restart disabled keeps phase
        freq_word = 14'd300; loop_restart = 1;
        cyc(1, 1, "R5");
        for (int i = 0; i < 5; i++) cyc(1, 0, "R9");
        cyc(0, 0, "R7");
        loop_restart = 0;
        cyc(1, 1, "R6");
        for (int i = 0; i < 10; i++) cyc(1, 0, "R6");

        // R7: gate off lets phase run while idle
        freq_word = 14'd400; gate_en = 0; loop_restart = 1;
        cyc(1, 1, "R7");
        for (int i = 0; i < 3; i++) cyc(0, 0, "R7");
        loop_restart = 0;
        cyc(1, 1, "R7");
        for (int i = 0; i < 10; i++) cyc(1, 0, "R7");
        gate_en = 1;
        cyc(0, 0, "R7");
        cyc(0, 0, "R7");

        // R10/R11: high idle level, swapped edges, async flag
        cyc(0, 0, "R10");
        cpol = 1; latch_rise = 0; launch_rise = 1; async_sel = 1;
        freq_word = 14'd700; loop_restart = 1;
        cyc(0, 0, "R10");
        cyc(1, 1, "R11");
        async_sel = 0;
        for (int i = 0; i < 14; i++) cyc(1, 0, "R10");
        // R4: busy drop mid transfer, then resume
        cyc(0, 0, "R4");
        cyc(0, 0, "R4");
        for (int i = 0; i < 6; i++) cyc(1, 0, "R9");
        // R12: start while running with a wrap pending
        cyc(1, 1, "R12");
        for (int i = 0; i < 6; i++) cyc(1, 0, "R12");
        cyc(0, 0, "R11");
        cyc(0, 0, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule